// File: doc/BRIEF.md
# Auto Exposure Hysteresis Controller

This block closes the exposure loop of an image sensor pipeline once per frame. On each frame strobe it takes a 12-bit luminance measurement, optionally smooths it with a first-order recursive filter, and compares the upper eight bits of the filtered value against a programmable target. When the scene is too dark or too bright it moves either the electronic shutter code or the AGC gain code by a step whose size depends on the error and a configurable speed option.

Control uses two nested tolerance bands around the target. Inside the narrow band the loop declares itself settled and freezes both settings. Once settled, it stays frozen until the measurement leaves the wide band. This gap stops the loop from hunting around the target. A backlight select swaps in a second, independent set of target and band values. A two-bit mode field makes the shutter and the gain each either automatic or fixed. Typical targets are 30h with bands 03h/06h, and 3Ah with bands 04h/08h for backlight.

Top module: `ae_hyst_ctrl`

## Requirements
- R1: After reset, shutCode is 75, gainCode is 0 (automatic mode), settled is 0, and the internal filter value is 0.
- R2: A frame strobe sampled at clock edge A loads the filter at A. At the next edge B, the controller evaluates and updates shutCode, gainCode and settled. The filter computes f + ((m - f) >>> k), with k = 3 for lpfSel 00 and k = 2 for lpfSel 01. For lpfSel 1x it loads m directly. The level that is compared is bits 11:4 of the filter value.
- R3: When not settled and |level - target| <= the narrow band, settled becomes 1 and neither setting changes.
- R4: When settled and |level - target| <= the wide band, both settings hold and settled stays 1.
- R5: When settled and |level - target| > the wide band, settled clears and an adjustment is made in that same evaluation. When not settled and the error is above the narrow band, an adjustment is made.
- R6: On a too-dark adjustment (level < target), the automatic shutter code grows, saturating at 149. Only when the shutter is fixed or already at 149 does the gain grow, saturating at 255.
- R7: On a too-bright adjustment, the gain falls first, saturating at 0, when AGC is on and the gain is above 0. Otherwise the automatic shutter code falls, saturating at the fastest limit.
- R8: stepSel 00 steps by 10 + min(err>>3, 9). stepSel 01 steps by 8 + min(err>>4, 2). stepSel 1x steps by 1.
- R9: shutMaxSel picks the smallest automatic shutter code: 00 gives 0, 01 gives 20, 10 gives 50, 11 gives 90. shutCode never exceeds 149.
- R10: modeSel bit 0 set makes the shutter fixed, and shutCode = min(fixedShut, 149). modeSel bit 1 set turns AGC off, and gainCode = presetGain. Fixed settings are never adjusted. The modes are 00 auto/on, 01 fixed/on, 10 auto/off and 11 fixed/off.
- R11: blcSel = 1 uses refBlc/innerBlc/outerBlc in place of refNorm/innerNorm/outerNorm.
- R12: The automatic settings change only in the evaluation that follows a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStb | input | 1 | One-cycle pulse per frame |
| lumaIn | input | 12 | Frame luminance measurement |
| blcSel | input | 1 | Selects the backlight target set |
| refNorm | input | 8 | Normal target level |
| innerNorm | input | 8 | Normal narrow (settle) band |
| outerNorm | input | 8 | Normal wide (restart) band |
| refBlc | input | 8 | Backlight target level |
| innerBlc | input | 8 | Backlight narrow band |
| outerBlc | input | 8 | Backlight wide band |
| modeSel | input | 2 | Bit 0 fixed shutter, bit 1 AGC off |
| stepSel | input | 2 | Step size option |
| lpfSel | input | 2 | Smoothing option |
| shutMaxSel | input | 2 | Fastest automatic shutter limit |
| fixedShut | input | 9 | Fixed shutter code |
| presetGain | input | 8 | Gain used while AGC is off |
| shutCode | output | 9 | Shutter code, larger is longer |
| gainCode | output | 8 | AGC gain code |
| settled | output | 1 | Loop settled flag |

## Verification
The bench targets the edges of the hysteresis. A level between the two bands must hold while settled and must keep adjusting while unsettled. A design that used a single band would hunt or would freeze too early. It drives the loop into shutter saturation to show the handover to gain, and then reverses it. A design with the priority wrong would move both knobs, or the wrong one, first. It also covers step saturation at both the 149 ceiling and the selected fastest limit, the fixed and AGC-off modes, the backlight swap, and a strong smoothing case. In that case a step in luminance that would restart an unfiltered loop must stay inside the wide band.

// File: rtl/ae_hyst_pkg.sv
package ae_hyst_pkg;
  localparam int LUMA_W   = 12;
  localparam int LVL_W    = 8;
  localparam int SHUT_W   = 9;
  localparam int GAIN_W   = 8;
  localparam int STEP_W   = 5;
  localparam int SHUT_TOP = 149;
  localparam int SHUT_RST = 75;

  typedef struct packed {
    logic              evalEn;
    logic              shutUp;
    logic              shutDn;
    logic              gainUp;
    logic              gainDn;
    logic [STEP_W-1:0] stepAmt;
  } aeStrobe_t;

  function automatic logic [SHUT_W-1:0] fastestCode(input logic [1:0] sel);
    case (sel)
      2'b00:   return SHUT_W'(0);
      2'b01:   return SHUT_W'(20);
      2'b10:   return SHUT_W'(50);
      default: return SHUT_W'(90);
    endcase
  endfunction
endpackage

// File: rtl/ae_hyst_datapath.sv
module ae_hyst_datapath
  import ae_hyst_pkg::*;
#(
  parameter int LW = LUMA_W,
  parameter int VW = LVL_W,
  parameter int SW = SHUT_W,
  parameter int GW = GAIN_W,
  parameter int TW = STEP_W,
  parameter int TOP = SHUT_TOP,
  parameter int RST = SHUT_RST
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStb,
  input  logic [LW-1:0] lumaIn,
  input  logic [1:0]    lpfSel,
  input  logic [1:0]    modeSel,
  input  logic [1:0]    shutMaxSel,
  input  logic [SW-1:0] fixedShut,
  input  logic [GW-1:0] presetGain,
  input  aeStrobe_t     strobe,
  output logic [VW-1:0] level,
  output logic          shutAtTop,
  output logic          shutAtMin,
  output logic          gainAtTop,
  output logic          gainAtMin,
  output logic [SW-1:0] shutAcc,
  output logic [GW-1:0] gainAcc,
  output logic [SW-1:0] shutCode,
  output logic [GW-1:0] gainCode
);
  localparam logic [SW-1:0] TOP_C = SW'(TOP);
  localparam logic [GW-1:0] GMAX  = '1;

  logic [LW-1:0]        filt;
  logic signed [LW:0]   diff;
  logic signed [LW:0]   delta;
  logic signed [LW:0]   filtSum;
  logic [SW-1:0]        minCode;
  logic [SW:0]          stepS;
  logic [GW:0]          stepG;
  logic [SW:0]          shutSum;
  logic [GW:0]          gainSum;
  logic [SW-1:0]        shutNext;
  logic [GW-1:0]        gainNext;

  // smoothing filter
  always_comb begin
    diff = $signed({1'b0, lumaIn}) - $signed({1'b0, filt});
    case (lpfSel)
      2'b00:   delta = diff >>> 3;
      2'b01:   delta = diff >>> 2;
      default: delta = diff;
    endcase
    filtSum = $signed({1'b0, filt}) + delta;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         filt <= '0;
    else if (frameStb) filt <= filtSum[LW-1:0];
  end

  assign level = filt[LW-1 -: VW];

  // saturation flags for the control
  assign minCode   = fastestCode(shutMaxSel);
  assign shutAtTop = (shutAcc >= TOP_C);
  assign shutAtMin = (shutAcc <= minCode);
  assign gainAtTop = (gainAcc == GMAX);
  assign gainAtMin = (gainAcc == '0);

  // saturating step arithmetic
  always_comb begin
    stepS    = {{(SW+1-TW){1'b0}}, strobe.stepAmt};
    stepG    = {{(GW+1-TW){1'b0}}, strobe.stepAmt};
    shutSum  = {1'b0, shutAcc} + stepS;
    gainSum  = {1'b0, gainAcc} + stepG;
    shutNext = shutAcc;
    gainNext = gainAcc;
    if (strobe.shutUp)
      shutNext = (shutSum > {1'b0, TOP_C}) ? TOP_C : shutSum[SW-1:0];
    else if (strobe.shutDn)
      shutNext = ({1'b0, shutAcc} < ({1'b0, minCode} + stepS)) ? minCode
                                                               : shutAcc - stepS[SW-1:0];
    if (strobe.gainUp)
      gainNext = gainSum[GW] ? GMAX : gainSum[GW-1:0];
    else if (strobe.gainDn)
      gainNext = ({1'b0, gainAcc} < stepG) ? '0 : gainAcc - stepG[GW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shutAcc <= SW'(RST);
      gainAcc <= '0;
    end else if (strobe.evalEn) begin
      shutAcc <= shutNext;
      gainAcc <= gainNext;
    end
  end

  // output selection by mode
  assign shutCode = modeSel[0] ? ((fixedShut > TOP_C) ? TOP_C : fixedShut) : shutAcc;
  assign gainCode = modeSel[1] ? presetGain : gainAcc;
endmodule

// File: rtl/ae_hyst_control.sv
module ae_hyst_control
  import ae_hyst_pkg::*;
#(
  parameter int VW = LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStb,
  input  logic [VW-1:0] level,
  input  logic          blcSel,
  input  logic [VW-1:0] refNorm,
  input  logic [VW-1:0] innerNorm,
  input  logic [VW-1:0] outerNorm,
  input  logic [VW-1:0] refBlc,
  input  logic [VW-1:0] innerBlc,
  input  logic [VW-1:0] outerBlc,
  input  logic [1:0]    modeSel,
  input  logic [1:0]    stepSel,
  input  logic          shutAtTop,
  input  logic          shutAtMin,
  input  logic          gainAtTop,
  input  logic          gainAtMin,
  output aeStrobe_t     strobe,
  output logic          settled
);
  logic          evalPend;
  logic [VW-1:0] refV, innerV, outerV, errMag;
  logic          dark, inInner, inOuter, adjust;
  logic          shutAuto, agcOn, gainCanDn;
  logic [VW-4:0] errDiv8;
  logic [VW-5:0] errDiv16;

  always_ff @(posedge clk) begin
    if (!rstN) evalPend <= 1'b0;
    else       evalPend <= frameStb;
  end

  always_comb begin
    refV   = blcSel ? refBlc   : refNorm;
    innerV = blcSel ? innerBlc : innerNorm;
    outerV = blcSel ? outerBlc : outerNorm;
    dark   = (level < refV);
    errMag = dark ? (refV - level) : (level - refV);
    inInner = (errMag <= innerV);
    inOuter = (errMag <= outerV);
    adjust  = evalPend && (settled ? !inOuter : !inInner);
    shutAuto  = !modeSel[0];
    agcOn     = !modeSel[1];
    gainCanDn = agcOn && !gainAtMin;
    errDiv8   = errMag[VW-1:3];
    errDiv16  = errMag[VW-1:4];
  end

  always_comb begin
    strobe = '0;
    strobe.evalEn = evalPend;
    case (stepSel)
      2'b00: strobe.stepAmt = STEP_W'(10) +
               ((errDiv8 > (VW-3)'(9)) ? STEP_W'(9) : STEP_W'(errDiv8));
      2'b01: strobe.stepAmt = STEP_W'(8) +
               ((errDiv16 > (VW-4)'(2)) ? STEP_W'(2) : STEP_W'(errDiv16));
      default: strobe.stepAmt = STEP_W'(1);
    endcase
    if (adjust) begin
      if (dark) begin
        if (shutAuto && !shutAtTop)   strobe.shutUp = 1'b1;
        else if (agcOn && !gainAtTop) strobe.gainUp = 1'b1;
      end else begin
        if (gainCanDn)                     strobe.gainDn = 1'b1;
        else if (shutAuto && !shutAtMin)   strobe.shutDn = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) settled <= 1'b0;
    else if (evalPend) begin
      if (settled && !inOuter)      settled <= 1'b0;
      else if (!settled && inInner) settled <= 1'b1;
    end
  end
endmodule

// File: rtl/ae_hyst_ctrl.sv
module ae_hyst_ctrl
  import ae_hyst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStb,
  input  logic [11:0] lumaIn,
  input  logic        blcSel,
  input  logic [7:0]  refNorm,
  input  logic [7:0]  innerNorm,
  input  logic [7:0]  outerNorm,
  input  logic [7:0]  refBlc,
  input  logic [7:0]  innerBlc,
  input  logic [7:0]  outerBlc,
  input  logic [1:0]  modeSel,
  input  logic [1:0]  stepSel,
  input  logic [1:0]  lpfSel,
  input  logic [1:0]  shutMaxSel,
  input  logic [8:0]  fixedShut,
  input  logic [7:0]  presetGain,
  output logic [8:0]  shutCode,
  output logic [7:0]  gainCode,
  output logic        settled
);
  aeStrobe_t          strobe;
  logic [LVL_W-1:0]   level;
  logic               shutAtTop, shutAtMin, gainAtTop, gainAtMin;
  logic [SHUT_W-1:0]  shutAcc;
  logic [GAIN_W-1:0]  gainAcc;

  ae_hyst_control u_ctl (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .level(level),
    .blcSel(blcSel), .refNorm(refNorm), .innerNorm(innerNorm), .outerNorm(outerNorm),
    .refBlc(refBlc), .innerBlc(innerBlc), .outerBlc(outerBlc),
    .modeSel(modeSel), .stepSel(stepSel),
    .shutAtTop(shutAtTop), .shutAtMin(shutAtMin),
    .gainAtTop(gainAtTop), .gainAtMin(gainAtMin),
    .strobe(strobe), .settled(settled)
  );

  ae_hyst_datapath u_dp (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .lumaIn(lumaIn),
    .lpfSel(lpfSel), .modeSel(modeSel), .shutMaxSel(shutMaxSel),
    .fixedShut(fixedShut), .presetGain(presetGain), .strobe(strobe),
    .level(level), .shutAtTop(shutAtTop), .shutAtMin(shutAtMin),
    .gainAtTop(gainAtTop), .gainAtMin(gainAtMin),
    .shutAcc(shutAcc), .gainAcc(gainAcc),
    .shutCode(shutCode), .gainCode(gainCode)
  );
endmodule

// File: rtl/ae_hyst_ctrl_chk.sv
module ae_hyst_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameStb,
  input logic [1:0] stepSel,
  input logic [8:0] shutCode,
  input logic [8:0] shutAcc,
  input logic [7:0] gainAcc,
  input logic       settled
);
  assert_shut_ceiling_R9: assert property (@(posedge clk) disable iff (!rstN)
    (shutCode <= 9'd149) && (shutAcc <= 9'd149));

  assert_hold_settled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (settled && $past(settled)) |-> ($stable(shutAcc) && $stable(gainAcc)));

  assert_frame_gated_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((shutAcc != $past(shutAcc)) || (gainAcc != $past(gainAcc))) |-> $past(frameStb, 2));

  assert_one_knob_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shutAcc != $past(shutAcc)) |-> (gainAcc == $past(gainAcc)));

  assert_fine_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stepSel[1]) && (shutAcc != $past(shutAcc))) |->
      (({1'b0, shutAcc} == {1'b0, $past(shutAcc)} + 10'd1) ||
       ({1'b0, shutAcc} + 10'd1 == {1'b0, $past(shutAcc)})));
endmodule

bind ae_hyst_ctrl ae_hyst_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .frameStb(frameStb), .stepSel(stepSel),
  .shutCode(shutCode), .shutAcc(shutAcc), .gainAcc(gainAcc), .settled(settled)
);

// File: tb/sim_ae_hyst_ctrl.sv
module sim_ae_hyst_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 1'b0;
  logic [11:0] lumaIn = '0;
  logic blcSel = 1'b0;
  logic [7:0] refNorm = 8'h30, innerNorm = 8'h03, outerNorm = 8'h06;
  logic [7:0] refBlc = 8'h3A, innerBlc = 8'h04, outerBlc = 8'h08;
  logic [1:0] modeSel = 2'b00, stepSel = 2'b10, lpfSel = 2'b10, shutMaxSel = 2'b00;
  logic [8:0] fixedShut = 9'd200;
  logic [7:0] presetGain = 8'h40;
  logic [8:0] shutCode;
  logic [7:0] gainCode;
  logic settled;

  int checks = 0, errors = 0;
  int mFilt = 0, mShut = 75, mGain = 0, mSet = 0;
  bit done = 0;

  typedef struct { int shut; int gain; int stl; string tag; } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  ae_hyst_ctrl u0 (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .lumaIn(lumaIn), .blcSel(blcSel),
    .refNorm(refNorm), .innerNorm(innerNorm), .outerNorm(outerNorm),
    .refBlc(refBlc), .innerBlc(innerBlc), .outerBlc(outerBlc),
    .modeSel(modeSel), .stepSel(stepSel), .lpfSel(lpfSel), .shutMaxSel(shutMaxSel),
    .fixedShut(fixedShut), .presetGain(presetGain),
    .shutCode(shutCode), .gainCode(gainCode), .settled(settled)
  );

  task automatic checkOut(input string tag, input int eS, input int eG, input int eT);
    checks++;
    if (shutCode !== eS[8:0] || gainCode !== eG[7:0] || settled !== eT[0]) begin
      errors++;
      $display("FAIL %s: shut/gain/settled actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, shutCode, gainCode, settled, eS, eG, eT);
    end
  endtask

  function automatic int expShut();
    if (modeSel[0]) return (fixedShut > 149) ? 149 : int'(fixedShut);
    return mShut;
  endfunction

  function automatic int expGain();
    return modeSel[1] ? int'(presetGain) : mGain;
  endfunction

  // driver: model the frame from the requirements and queue the result
  task automatic frame(input int lum, input string tag);
    int lvl, rf, inr, otr, err, step, minc, diff;
    bit dark, adj;
    exp_t e;
    diff = lum - mFilt;
    if (lpfSel[1]) mFilt = lum;
    else if (lpfSel == 2'b00) mFilt = mFilt + (diff >>> 3);
    else mFilt = mFilt + (diff >>> 2);
    lvl = mFilt >> 4;
    rf  = blcSel ? refBlc : refNorm;
    inr = blcSel ? innerBlc : innerNorm;
    otr = blcSel ? outerBlc : outerNorm;
    dark = lvl < rf;
    err  = dark ? rf - lvl : lvl - rf;
    adj  = mSet ? (err > otr) : (err > inr);
    if (stepSel == 2'b00) step = 10 + (((err >> 3) > 9) ? 9 : (err >> 3));
    else if (stepSel == 2'b01) step = 8 + (((err >> 4) > 2) ? 2 : (err >> 4));
    else step = 1;
    case (shutMaxSel)
      2'b00: minc = 0;
      2'b01: minc = 20;
      2'b10: minc = 50;
      default: minc = 90;
    endcase
    if (adj) begin
      if (dark) begin
        if (!modeSel[0] && mShut < 149) mShut = (mShut + step > 149) ? 149 : mShut + step;
        else if (!modeSel[1] && mGain < 255) mGain = (mGain + step > 255) ? 255 : mGain + step;
      end else begin
        if (!modeSel[1] && mGain > 0) mGain = (mGain < step) ? 0 : mGain - step;
        else if (!modeSel[0] && mShut > minc) mShut = (mShut < minc + step) ? minc : mShut - step;
      end
    end
    if (mSet == 1 && err > otr) mSet = 0;
    else if (mSet == 0 && err <= inr) mSet = 1;
    e.shut = expShut(); e.gain = expGain(); e.stl = mSet; e.tag = tag;
    @(negedge clk);
    lumaIn = lum[11:0];
    frameStb = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    frameStb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: evaluation lands one edge after the strobe is captured
  initial begin
    forever begin
      @(posedge clk);
      if (frameStb) begin
        exp_t e;
        @(posedge clk);
        @(negedge clk);
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: result with empty queue actual %0d expected queued item", shutCode);
        end else begin
          e = expQ.pop_front();
          checkOut(e.tag, e.shut, e.gain, e.stl);
        end
      end
    end
  end

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: run hung actual running expected done");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 reset", 75, 0, 0);

    // dark, fine steps: shutter first
    for (int i = 0; i < 3; i++) frame(40 << 4, "R6 fine dark");
    // coarse steps drive shutter to ceiling, then gain takes over
    stepSel = 2'b00;
    for (int i = 0; i < 7; i++) frame(0, "R6 R8 coarse dark");
    // settle at target
    frame(48 << 4, "R3 settle");
    frame(53 << 4, "R4 hold above");
    frame(43 << 4, "R4 hold below");
    frame(54 << 4, "R4 hold at wide edge");
    // restart beyond wide band, bright: gain first
    frame(60 << 4, "R5 R7 restart");
    for (int i = 0; i < 4; i++) frame(60 << 4, "R7 bright gain first");
    stepSel = 2'b01;
    for (int i = 0; i < 4; i++) frame(255 << 4, "R7 R8 medium bright shutter");
    // fastest limit
    shutMaxSel = 2'b11;
    for (int i = 0; i < 8; i++) frame(255 << 4, "R9 fastest limit");
    // backlight set
    blcSel = 1'b1; stepSel = 2'b10;
    frame(56 << 4, "R11 backlight settle");
    frame(52 << 4, "R11 backlight hold");
    frame(49 << 4, "R11 backlight restart");
    blcSel = 1'b0;
    // idle: nothing moves between frames
    repeat (20) @(negedge clk);
    checkOut("R12 idle", mShut, mGain, mSet);
    // modes
    modeSel = 2'b01;
    @(negedge clk);
    checkOut("R10 fixed shutter clamp", 149, mGain, mSet);
    frame(0, "R10 fixed shutter dark to gain");
    modeSel = 2'b11;
    @(negedge clk);
    checkOut("R10 fixed both", 149, 8'h40, mSet);
    frame(0, "R10 fixed both no change");
    modeSel = 2'b10; fixedShut = 9'd100;
    frame(0, "R10 agc off shutter moves");
    modeSel = 2'b00;
    // settle, then smoothing keeps a step inside the wide band
    frame(48 << 4, "R3 resettle");
    frame(48 << 4, "R3 resettle 2");
    lpfSel = 2'b00;
    frame(64 << 4, "R2 smoothing 1/8");
    lpfSel = 2'b01;
    frame(64 << 4, "R2 smoothing 1/4");
    frame(64 << 4, "R2 smoothing 1/4 b");
    frame(0, "R2 smoothing fall");
    repeat (6) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: pending results actual %0d expected 0", expQ.size());
    end
    finishRun();
  end
endmodule